// File: doc/BRIEF.md
# Variable Bit-Field Unit

This unit reads, writes, compares and searches a bit field of variable length held inside a 64-bit data window. A field is named by a bit offset into the window and a length of 0 to 32 bits. Each request gives an opcode together with the window, the offset, the length and a 32-bit operand. One clock later the unit presents a 32-bit result, a copy of the window (changed only by an insert), four condition flags and a fault bit.

Extracts return the field widened to 32 bits, either with its top bit copied upward or with zeros filled in. Inserts place the low bits of the operand into the field. Compares set the flags from the widened field minus the operand. Searches return the window bit position of the lowest field bit that is set or clear. The flags are held in a register, so an operation that does not define a flag keeps its earlier value. Requests arrive on a simple valid strobe and may be issued back to back.

Top module: `bfu_unit`

## Requirements
- R1: Opcodes are 0 signed extract, 1 unsigned extract, 2 insert, 3 signed compare, 4 unsigned compare, 5 find set, 6 find clear, 7 reserved. A request with `op_valid` high gives `res_valid` high exactly one cycle later. With no request, `res_valid` is low. Reset clears `res_valid`, `result`, `win_out`, `flags` and `fault`.
- R2: Unsigned extract returns bits offset to offset+len-1 of the window in result bits 0 to len-1, with zeros above them.
- R3: Signed extract fills every result bit above len-1 with field bit len-1. A length of 0 returns 0.
- R4: An extract sets N (flags[3]) to result bit 31 and Z (flags[2]) to whether the result is zero. It clears V (flags[1]) and leaves C (flags[0]) unchanged.
- R5: Insert copies the low len bits of `value` into window bits offset to offset+len-1 and leaves every other window bit alone. A length of 0 leaves the window unchanged. Insert returns 0 and leaves all four flags unchanged.
- R6: A compare widens the field (signed for opcode 3, unsigned for opcode 4) and compares it with `value`. N is set when the widened field is below `value` as signed numbers. Z is set when they are equal. V is cleared. C is set when the widened field is below `value` as unsigned numbers. The result is 0.
- R7: A search scans the field from its lowest bit upward for a 1 (opcode 5) or a 0 (opcode 6). If it finds one, the result is offset plus that bit's index in the field and Z is 0. If not, the result is offset+len and Z is 1. N and V are cleared and C is unchanged.
- R8: A length above 32, an offset+len above 64 (both taken as unsigned), or opcode 7 raises `fault`. A faulting request returns 0, passes the window through unchanged and leaves all flags unchanged.
- R9: Every request that is not a non-faulting insert returns `win_out` equal to `win_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| win_in | input | 64 | Data window |
| offset | input | 32 | Field bit offset |
| len | input | 8 | Field length in bits |
| value | input | 32 | Insert data or compare operand |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| result | output | 32 | Extracted field, found position, or 0 |
| win_out | output | 64 | Window after the operation |
| flags | output | 4 | {N, Z, V, C} |
| fault | output | 1 | Reserved-operand or out-of-window fault |

## Verification
Two behaviours can land on the same result cycle. The first is a fault and an insert in one request: the window must come back untouched and the flags held, even though the insert path has already built a modified window. The bench issues inserts whose field runs past bit 63, or whose length exceeds 32, and checks that `win_out` equals the input. The second is a compare followed at once by an insert and then an extract. The flags set by the compare must survive the insert, and the C flag must survive the extract. A scoreboard model that carries its own copy of the flags checks every result.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int WIN_W  = 64;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 8;
    localparam int OFF_W  = 32;
    localparam int SH_W   = $clog2(WIN_W) + 1;
    localparam int IX_W   = $clog2(DATA_W);

    typedef enum logic [2:0] {
        OP_EXTS = 3'd0,
        OP_EXTU = 3'd1,
        OP_INS  = 3'd2,
        OP_CMPS = 3'd3,
        OP_CMPU = 3'd4,
        OP_FFS  = 3'd5,
        OP_FFC  = 3'd6,
        OP_RSVD = 3'd7
    } bf_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } bf_flags_t;

    // Ones in the low len positions; meaningful for len <= DATA_W.
    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [DATA_W:0] m;
        m = ({{DATA_W{1'b0}}, 1'b1} << len) - 1'b1;
        return m[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/bfu_extract.sv
module bfu_extract
    import bfu_pkg::*;
#(
    parameter int WW = WIN_W,
    parameter int DW = DATA_W,
    parameter int LW = LEN_W,
    parameter int SW = SH_W
) (
    input  logic [WW-1:0] win,
    input  logic [SW-1:0] sh,
    input  logic [LW-1:0] len,
    input  logic          sign_mode,
    output logic [DW-1:0] field_raw,
    output logic [DW-1:0] field_ext
);
    localparam int IXW = $clog2(DW);

    logic [WW-1:0] shifted;
    logic [DW-1:0] msk;
    logic [LW-1:0] top_pos;
    logic          sign_bit;

    always_comb begin
        shifted   = win >> sh;
        msk       = len_mask(len);
        field_raw = shifted[DW-1:0] & msk;
        top_pos   = len - 1'b1;
        sign_bit  = (len != '0) && field_raw[top_pos[IXW-1:0]];
        field_ext = (sign_mode && sign_bit) ? (field_raw | ~msk) : field_raw;
    end
endmodule

// File: rtl/bfu_search.sv
module bfu_search
    import bfu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LEN_W
) (
    input  logic [DW-1:0]         field_raw,
    input  logic [LW-1:0]         len,
    input  logic                  want_set,
    output logic                  found,
    output logic [$clog2(DW)-1:0] idx
);
    localparam int IXW = $clog2(DW);

    // Descending scan so the lowest matching bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if ((i < int'(len)) && (field_raw[i] == want_set)) begin
                found = 1'b1;
                idx   = IXW'(i);
            end
        end
    end
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert
    import bfu_pkg::*;
#(
    parameter int WW = WIN_W,
    parameter int DW = DATA_W,
    parameter int LW = LEN_W,
    parameter int SW = SH_W
) (
    input  logic [WW-1:0] win,
    input  logic [SW-1:0] sh,
    input  logic [LW-1:0] len,
    input  logic [DW-1:0] value,
    output logic [WW-1:0] win_new
);
    logic [DW-1:0] msk;
    logic [WW-1:0] place_mask;
    logic [WW-1:0] place_val;

    always_comb begin
        msk        = len_mask(len);
        place_mask = {{(WW-DW){1'b0}}, msk} << sh;
        place_val  = {{(WW-DW){1'b0}}, value & msk} << sh;
        win_new    = (win & ~place_mask) | place_val;
    end
endmodule

// File: rtl/bfu_unit.sv
module bfu_unit
    import bfu_pkg::*;
#(
    parameter int WW = WIN_W,
    parameter int DW = DATA_W,
    parameter int LW = LEN_W,
    parameter int OW = OFF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [2:0]    op,
    input  logic [WW-1:0] win_in,
    input  logic [OW-1:0] offset,
    input  logic [LW-1:0] len,
    input  logic [DW-1:0] value,
    output logic          res_valid,
    output logic [DW-1:0] result,
    output logic [WW-1:0] win_out,
    output logic [3:0]    flags,
    output logic          fault
);
    localparam int SW  = $clog2(WW) + 1;
    localparam int IXW = $clog2(DW);

    bf_op_e        opc;
    logic [OW:0]   span;
    logic          bad;
    logic [SW-1:0] sh;
    logic          sign_mode;
    logic [DW-1:0] f_raw, f_ext;
    logic          hit;
    logic [IXW-1:0] hit_idx;
    logic [WW-1:0] ins_win;
    logic [DW:0]   diff;

    logic [DW-1:0] nxt_result;
    logic [WW-1:0] nxt_win;
    bf_flags_t     nxt_flags;
    bf_flags_t     flags_q;

    assign opc       = bf_op_e'(op);
    assign span      = {1'b0, offset} + {{(OW+1-LW){1'b0}}, len};
    assign bad       = (len > LW'(DW)) || (span > (OW+1)'(WW)) || (opc == OP_RSVD);
    assign sh        = offset[SW-1:0];
    assign sign_mode = (opc == OP_EXTS) || (opc == OP_CMPS);

    bfu_extract #(.WW(WW), .DW(DW), .LW(LW), .SW(SW)) u_ext (
        .win(win_in), .sh(sh), .len(len), .sign_mode(sign_mode),
        .field_raw(f_raw), .field_ext(f_ext)
    );

    bfu_search #(.DW(DW), .LW(LW)) u_srch (
        .field_raw(f_raw), .len(len), .want_set(opc == OP_FFS),
        .found(hit), .idx(hit_idx)
    );

    bfu_insert #(.WW(WW), .DW(DW), .LW(LW), .SW(SW)) u_ins (
        .win(win_in), .sh(sh), .len(len), .value(value), .win_new(ins_win)
    );

    always_comb begin
        nxt_result = '0;
        nxt_win    = win_in;
        nxt_flags  = flags_q;
        diff       = {1'b0, f_ext} - {1'b0, value};
        if (!bad) begin
            unique case (opc)
                OP_EXTS, OP_EXTU: begin
                    nxt_result  = f_ext;
                    nxt_flags.n = f_ext[DW-1];
                    nxt_flags.z = (f_ext == '0);
                    nxt_flags.v = 1'b0;
                end
                OP_INS: begin
                    nxt_win = ins_win;
                end
                OP_CMPS, OP_CMPU: begin
                    nxt_flags.n = $signed(f_ext) < $signed(value);
                    nxt_flags.z = (f_ext == value);
                    nxt_flags.v = 1'b0;
                    nxt_flags.c = diff[DW];
                end
                OP_FFS, OP_FFC: begin
                    nxt_result  = hit ? DW'(offset + {{(OW-IXW){1'b0}}, hit_idx})
                                      : DW'(offset + {{(OW-LW){1'b0}}, len});
                    nxt_flags.n = 1'b0;
                    nxt_flags.z = !hit;
                    nxt_flags.v = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            result    <= '0;
            win_out   <= '0;
            flags_q   <= '0;
            fault     <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                result  <= nxt_result;
                win_out <= nxt_win;
                flags_q <= nxt_flags;
                fault   <= bad;
            end
        end
    end

    assign flags = flags_q;

    // R1: every request produces a result strobe one cycle later
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R1: no strobe without a request
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    // R4: extracts never leave V set
    p_ext_vclear_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !bad && (opc == OP_EXTS || opc == OP_EXTU)) |=> !flags[1]);

    // R5: insert keeps flags
    p_ins_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opc == OP_INS) |=> $stable(flags));

    // R8: a fault passes the window through and holds flags
    p_fault_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && bad) |=> (fault && win_out == $past(win_in) && result == '0 && $stable(flags)));

    // R7: a search that found nothing reports Z
    p_search_z_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !bad && (opc == OP_FFS || opc == OP_FFC) && !hit) |=> flags[2]);

endmodule

// File: tb/bfu_unit_test.sv
`timescale 1ns/1ps
module bfu_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [63:0] win_in = '0;
    logic [31:0] offset = '0;
    logic [7:0]  len = '0;
    logic [31:0] value = '0;
    logic        res_valid;
    logic [31:0] result;
    logic [63:0] win_out;
    logic [3:0]  flags;
    logic        fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [31:0] res;
        logic [63:0] w;
        logic [3:0]  fl;
        logic        flt;
    } exp_t;

    exp_t  expq[$];
    string reqq[$];
    logic [3:0] mflags = 4'b0;

    always #10 clk = ~clk;

    bfu_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .win_in(win_in),
        .offset(offset), .len(len), .value(value), .res_valid(res_valid),
        .result(result), .win_out(win_out), .flags(flags), .fault(fault)
    );

    function automatic exp_t model(input logic [2:0] o, input logic [63:0] w,
                                   input logic [31:0] off, input logic [7:0] ln,
                                   input logic [31:0] v, input logic [3:0] fin);
        exp_t e;
        logic [31:0] fld;
        logic [31:0] fs;
        longint unsigned endp;
        int idx;
        e.res = '0; e.w = w; e.fl = fin; e.flt = 1'b0;
        endp = longint'(off) + longint'(ln);
        if (ln > 8'd32 || endp > 64 || o == 3'd7) begin
            e.flt = 1'b1;
            return e;
        end
        fld = '0;
        for (int i = 0; i < int'(ln); i++) fld[i] = w[int'(off) + i];
        fs = fld;
        if (ln != 0 && fld[ln-1])
            for (int i = int'(ln); i < 32; i++) fs[i] = 1'b1;
        case (o)
            3'd0, 3'd1: begin
                e.res = (o == 3'd0) ? fs : fld;
                e.fl[3] = e.res[31];
                e.fl[2] = (e.res == 0);
                e.fl[1] = 1'b0;
            end
            3'd2: for (int i = 0; i < int'(ln); i++) e.w[int'(off) + i] = v[i];
            3'd3, 3'd4: begin
                logic [31:0] a;
                a = (o == 3'd3) ? fs : fld;
                e.fl[3] = $signed(a) < $signed(v);
                e.fl[2] = (a == v);
                e.fl[1] = 1'b0;
                e.fl[0] = (a < v);
            end
            default: begin
                idx = -1;
                for (int i = 0; i < int'(ln); i++)
                    if (idx < 0 && fld[i] == (o == 3'd5)) idx = i;
                e.res = (idx < 0) ? off + 32'(ln) : off + 32'(idx);
                e.fl[3] = 1'b0;
                e.fl[2] = (idx < 0);
                e.fl[1] = 1'b0;
            end
        endcase
        return e;
    endfunction

    task automatic drive(input logic [2:0] o, input logic [63:0] w,
                         input logic [31:0] off, input logic [7:0] ln,
                         input logic [31:0] v, input string req);
        exp_t e;
        @(negedge clk);
        e = model(o, w, off, ln, v, mflags);
        mflags = e.fl;
        expq.push_back(e);
        reqq.push_back(req);
        op = o; win_in = w; offset = off; len = ln; value = v;
        op_valid = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            exp_t  e;
            string r;
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R1: result strobe with nothing expected (actual res_valid=1, expected 0)");
            end else begin
                e = expq.pop_front();
                r = reqq.pop_front();
                if (result !== e.res || win_out !== e.w || flags !== e.fl || fault !== e.flt) begin
                    fails++;
                    $display("FAIL %s: actual res=%h win=%h fl=%b flt=%b expected res=%h win=%h fl=%b flt=%b",
                             r, result, win_out, flags, fault, e.res, e.w, e.fl, e.flt);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (res_valid !== 1'b0 || result !== '0 || win_out !== '0 || flags !== '0 || fault !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset state actual v=%b r=%h w=%h f=%b x=%b expected all zero",
                     res_valid, result, win_out, flags, fault);
        end

        drive(3'd1, 64'h0123_4567_89AB_CDEF, 32'd4,  8'd12, 32'd0, "R2 unsigned extract");
        drive(3'd0, 64'h0000_0000_8000_0000, 32'd24, 8'd8,  32'd0, "R3 R4 signed extract negative");
        drive(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 32'd10, 8'd0,  32'd0, "R3 signed extract len0");
        drive(3'd0, 64'h7654_3210_0000_0001, 32'd32, 8'd32, 32'd0, "R3 signed extract upper word");
        drive(3'd1, 64'h0000_0000_0000_00F0, 32'd4,  8'd4,  32'd0, "R2 unsigned extract all ones");
        drive(3'd3, 64'h0000_0000_0000_00F0, 32'd4,  8'd4,  32'd1, "R6 signed compare negative");
        drive(3'd2, 64'h0123_4567_89AB_CDEF, 32'd60, 8'd4,  32'hFFFF_FFFA, "R5 insert top nibble flags held");
        drive(3'd1, 64'h0000_0000_0000_0000, 32'd0,  8'd16, 32'd0, "R4 extract keeps C");
        drive(3'd4, 64'h0000_0000_0000_00F0, 32'd4,  8'd4,  32'd15, "R6 unsigned compare equal");
        drive(3'd4, 64'h0000_0000_0000_0030, 32'd4,  8'd4,  32'd5, "R6 unsigned compare below");
        drive(3'd2, 64'hAAAA_5555_AAAA_5555, 32'd7,  8'd0,  32'hFFFF_FFFF, "R5 insert len0 unchanged");
        drive(3'd2, 64'h0000_0000_0000_0000, 32'd16, 8'd32, 32'hDEAD_BEEF, "R5 insert full word");
        drive(3'd5, 64'h0000_0100_0000_0000, 32'd20, 8'd30, 32'd0, "R7 find set hit");
        drive(3'd5, 64'h0000_0000_0000_FF00, 32'd16, 8'd20, 32'd0, "R7 find set none");
        drive(3'd6, 64'hFFFF_FFFF_FFFF_F7FF, 32'd3,  8'd20, 32'd0, "R7 find clear hit");
        drive(3'd6, 64'hFFFF_FFFF_0000_0000, 32'd32, 8'd32, 32'd0, "R7 find clear none");
        drive(3'd1, 64'h1234_5678_9ABC_DEF0, 32'd0,  8'd33, 32'd0, "R8 fault long length");
        drive(3'd2, 64'h1234_5678_9ABC_DEF0, 32'd60, 8'd8,  32'hFF, "R8 R9 fault insert past window");
        drive(3'd7, 64'h1111_2222_3333_4444, 32'd0,  8'd4,  32'd0, "R8 reserved opcode");
        drive(3'd0, 64'h1111_2222_3333_4444, 32'hFFFF_FFF0, 8'd16, 32'd0, "R8 offset wrap fault");
        drive(3'd2, 64'h0, 32'd64, 8'd0, 32'h1, "R5 empty field at window end");
        drive(3'd3, 64'hDEAD_BEEF_0000_0000, 32'd32, 8'd32, 32'hDEAD_BEEF, "R6 R9 signed compare equal");
        idle();
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: idle strobe actual %b expected 0", res_valid);
        end
        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R1: results missing actual pending %0d expected 0", expq.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1: watchdog expired actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule